// File: doc/BRIEF.md
# Device-Side DMA Configuration and Burst Sequencer

This block holds the DMA settings of the device side of a full-speed USB controller and runs the byte-moving handshake toward an external bus master. The host processor writes and reads a 16-bit configuration word through two command codes. Command code 0xF0 writes the word and code 0xF1 reads it. The word selects an endpoint, a burst size, an enable and two stop conditions.

While the enable is set, the block requests the bus master whenever the chosen endpoint holds enough bytes or free space for one whole burst. It holds the request until every byte of the burst has been acknowledged. A separate 16-bit byte counter, loaded by the processor, counts down once per acknowledged byte.

A transfer ends in one of three ways:
- the counter reaches zero, when counter-stop is armed;
- the selected endpoint reports a short or empty packet, when short-packet stop is armed;
- software writes the enable to zero.

Each ending produces a one-cycle end-of-transfer pulse, clears the enable and sets a sticky interrupt. The processor clears the interrupt with an acknowledge strobe. A bus reset clears only the enable. A hardware reset clears everything.

Top module: `dev_dma_sequencer`

## Requirements
- R1: After hardware reset the configuration word reads 0x0000, the counter is 0, and `dreq`, `eot` and `irq` are low.
- R2: A command with code 0xF0 and `cmd_valid` high writes the word. Its layout is: bit 15 counter-stop enable, bit 14 short-packet stop enable, bits 7:4 endpoint index, bit 3 DMA enable, bits 1:0 burst code. While `cmd_valid` is high with code 0xF1, `cmd_rdata` shows the word; otherwise it shows 0. Bits 13:8 and bit 2 read as 0 and ignore writes, so writing 0xFFFF reads back 0xC0FB. A command with any other code changes nothing.
- R3: The burst code sets the burst size: 00 gives 1 byte, 01 gives 4, 10 gives 8, 11 gives 16. When idle between bursts, `dreq` goes high only if the enable is set and the level of the selected endpoint (`ep_level` slice `[idx*5 +: 5]`) is at least the burst size. Levels of other endpoints have no effect.
- R4: Once a burst has started, `dreq` stays high until the full burst size has been acknowledged (`dack` high while `dreq` is high), whatever the endpoint level does.
- R5: `cnt_load` loads `cnt_wdata` into the counter. Each acknowledged byte lowers it by one. With counter-stop enabled, the byte that takes it from 1 to 0 causes end of transfer. `eot` and `irq` are high and `dreq` and the enable are low in the next cycle.
- R6: The counter saturates at 0. With counter-stop disabled, reaching 0 causes no end of transfer, and the enable stays set.
- R7: With short-packet stop enabled and DMA enabled, a pulse on `short_pkt[idx]` for the selected endpoint causes end of transfer. A pulse for another endpoint does not. With short-packet stop disabled, a pulse does not either.
- R8: Writing the enable to 0 while it is 1 aborts at once with an end of transfer. Writing 0 while it is already 0 gives no `eot`.
- R9: `eot` is a single-cycle pulse. `irq` is set by every end of transfer and stays set until an `irq_ack` pulse.
- R10: `bus_reset` clears the enable bit and keeps the counter-stop, short-packet, endpoint and burst fields.
- R11: `dreq` is low whenever the enable is clear, whatever the endpoint levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, clears everything |
| bus_reset | input | 1 | USB bus reset strobe, clears the enable only |
| cmd_valid | input | 1 | Command strobe from the processor port |
| cmd_code | input | 8 | Command code (0xF0 write, 0xF1 read) |
| cmd_wdata | input | 16 | Write data for code 0xF0 |
| cmd_rdata | output | 16 | Configuration word while a read command is present |
| cnt_load | input | 1 | Load strobe for the byte counter |
| cnt_wdata | input | 16 | Byte counter load value |
| dma_count | output | 16 | Current byte counter value |
| ep_level | input | NUM_EP*LVL_W | Bytes available (OUT) or free space (IN) for each endpoint |
| short_pkt | input | NUM_EP | Short or empty packet strobe for each endpoint |
| dreq | output | 1 | DMA request to the bus master |
| dack | input | 1 | DMA acknowledge, one byte per cycle |
| eot | output | 1 | End-of-transfer pulse |
| irq | output | 1 | Sticky end-of-transfer interrupt |
| irq_ack | input | 1 | Clears `irq` |

## Verification
The bench drives levels just below and exactly at each burst size. A wrong threshold or a wrong burst decode would raise the request one byte early or hold it back. It drops the endpoint level in the middle of a burst, where a design that re-checks the level per byte would cut the burst short. It runs the counter down with counter-stop both on and off, and keeps acknowledging past zero: an unsaturated counter would wrap to 0xFFFF, and an ungated stop would end transfers that should run on. It sends short-packet strobes to the wrong endpoint and with the mode off, writes a zero enable while stopped, and checks after a bus reset that only the enable was lost.

// File: rtl/dev_dma_pkg.sv
package dev_dma_pkg;
   localparam logic [7:0]  CMD_CFG_WR = 8'hF0;
   localparam logic [7:0]  CMD_CFG_RD = 8'hF1;
   localparam logic [15:0] CFG_MASK   = 16'hC0FB;
   localparam int          BLEN_W     = 5;

   typedef struct packed {
      logic       cnt_stop;
      logic       short_stop;
      logic [3:0] ep_idx;
      logic       enable;
      logic [1:0] burst;
   } dma_cfg_t;

   function automatic logic [BLEN_W-1:0] burst_bytes(input logic [1:0] code);
      case (code)
         2'b00:   burst_bytes = 5'd1;
         2'b01:   burst_bytes = 5'd4;
         2'b10:   burst_bytes = 5'd8;
         default: burst_bytes = 5'd16;
      endcase
   endfunction

   function automatic logic [15:0] pack_cfg(input dma_cfg_t c);
      pack_cfg = {c.cnt_stop, c.short_stop, 6'd0, c.ep_idx, c.enable, 1'b0, c.burst};
   endfunction
endpackage

// File: rtl/dma_cfg_reg.sv
module dma_cfg_reg
   import dev_dma_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_reset,
   input  logic            wr_en,
   input  logic [15:0]     wr_data,
   input  logic            stop_evt,
   output dma_cfg_t        cfg
);
   dma_cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else begin
         if (wr_en) begin
            cfg_q.cnt_stop   <= wr_data[15];
            cfg_q.short_stop <= wr_data[14];
            cfg_q.ep_idx     <= wr_data[7:4];
            cfg_q.burst      <= wr_data[1:0];
         end
         if (bus_reset)
            cfg_q.enable <= 1'b0;
         else if (wr_en)
            cfg_q.enable <= wr_data[3];
         else if (stop_evt)
            cfg_q.enable <= 1'b0;
      end
   end

   assign cfg = cfg_q;
endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             byte_done,
   output logic [CNT_W-1:0] count,
   output logic             hit_zero
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (byte_done && cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign count    = cnt_q;
   assign hit_zero = byte_done && !load && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/dma_burst_ctrl.sv
module dma_burst_ctrl
   import dev_dma_pkg::*;
#(
   parameter int NUM_EP = 16,
   parameter int LVL_W  = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    enable,
   input  logic                    flush,
   input  logic [3:0]              ep_idx,
   input  logic [1:0]              burst,
   input  logic [NUM_EP*LVL_W-1:0] ep_level,
   input  logic                    dack,
   output logic                    dreq,
   output logic                    byte_done
);
   localparam int BEAT_W = BLEN_W;

   logic [LVL_W-1:0] lvl_arr [NUM_EP];
   logic [LVL_W-1:0] sel_lvl;
   logic [BEAT_W-1:0] beat_q;
   logic [BLEN_W-1:0] blen;

   for (genvar e = 0; e < NUM_EP; e++) begin : g_lvl
      assign lvl_arr[e] = ep_level[e*LVL_W +: LVL_W];
   end

   always_comb begin
      sel_lvl = '0;
      for (int e = 0; e < NUM_EP; e++)
         if (ep_idx == 4'(e)) sel_lvl = lvl_arr[e];
   end

   assign blen      = burst_bytes(burst);
   assign dreq      = enable && ((beat_q != '0) || (sel_lvl >= LVL_W'(blen)));
   assign byte_done = dreq && dack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         beat_q <= '0;
      else if (flush || !enable)
         beat_q <= '0;
      else if (byte_done)
         beat_q <= (beat_q == blen - 1'b1) ? '0 : beat_q + 1'b1;
   end
endmodule

// File: rtl/dev_dma_sequencer.sv
module dev_dma_sequencer
   import dev_dma_pkg::*;
#(
   parameter int NUM_EP = 16,
   parameter int LVL_W  = 5,
   parameter int CNT_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_reset,
   input  logic                    cmd_valid,
   input  logic [7:0]              cmd_code,
   input  logic [15:0]             cmd_wdata,
   output logic [15:0]             cmd_rdata,
   input  logic                    cnt_load,
   input  logic [CNT_W-1:0]        cnt_wdata,
   output logic [CNT_W-1:0]        dma_count,
   input  logic [NUM_EP*LVL_W-1:0] ep_level,
   input  logic [NUM_EP-1:0]       short_pkt,
   output logic                    dreq,
   input  logic                    dack,
   output logic                    eot,
   output logic                    irq,
   input  logic                    irq_ack
);
   if (NUM_EP < 1 || NUM_EP > 16) begin : g_bad_ep
      $error("NUM_EP must be 1..16");
   end
   if (LVL_W < BLEN_W) begin : g_bad_lvl
      $error("LVL_W too narrow for a 16-byte burst");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end

   dma_cfg_t cfg;
   logic     cfg_wr, cfg_rd, cfg_en;
   logic     byte_done, cnt_zero_hit;
   logic     stop_cnt, stop_short, stop_abort, stop_evt;
   logic     sel_short;
   logic     eot_q, irq_q;

   assign cfg_wr = cmd_valid && (cmd_code == CMD_CFG_WR);
   assign cfg_rd = cmd_valid && (cmd_code == CMD_CFG_RD);
   assign cfg_en = cfg.enable;

   always_comb begin
      sel_short = 1'b0;
      for (int e = 0; e < NUM_EP; e++)
         if (cfg.ep_idx == 4'(e)) sel_short = short_pkt[e];
   end

   assign stop_cnt   = cfg.cnt_stop && cnt_zero_hit;
   assign stop_short = cfg_en && cfg.short_stop && sel_short;
   assign stop_abort = cfg_wr && cfg_en && !cmd_wdata[3];
   assign stop_evt   = !bus_reset && (stop_cnt || stop_short || stop_abort);

   dma_cfg_reg u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_reset(bus_reset),
      .wr_en    (cfg_wr),
      .wr_data  (cmd_wdata),
      .stop_evt (stop_evt),
      .cfg      (cfg)
   );

   dma_burst_ctrl #(.NUM_EP(NUM_EP), .LVL_W(LVL_W)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (cfg_en),
      .flush    (stop_evt || bus_reset),
      .ep_idx   (cfg.ep_idx),
      .burst    (cfg.burst),
      .ep_level (ep_level),
      .dack     (dack),
      .dreq     (dreq),
      .byte_done(byte_done)
   );

   dma_xfer_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_wdata),
      .byte_done(byte_done),
      .count    (dma_count),
      .hit_zero (cnt_zero_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eot_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         eot_q <= stop_evt;
         if (stop_evt)
            irq_q <= 1'b1;
         else if (irq_ack)
            irq_q <= 1'b0;
      end
   end

   assign eot       = eot_q;
   assign irq       = irq_q;
   assign cmd_rdata = cfg_rd ? (pack_cfg(cfg) & CFG_MASK) : 16'h0000;
endmodule

// File: rtl/dev_dma_sequencer_chk.sv
module dev_dma_sequencer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_reset,
   input logic             cmd_valid,
   input logic [7:0]       cmd_code,
   input logic             cnt_load,
   input logic [CNT_W-1:0] dma_count,
   input logic             dreq,
   input logic             dack,
   input logic             eot,
   input logic             irq,
   input logic             irq_ack,
   input logic             en
);
   // R11
   dreq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dreq |-> en);

   // R9
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_ack) |=> irq);

   // R9
   eot_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eot |-> irq);

   // R6
   cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_count == '0 && !cnt_load) |=> dma_count == '0);

   // R5
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dreq && dack && !cnt_load && dma_count != '0) |=> dma_count == $past(dma_count) - 1'b1);

   // R10
   bus_reset_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> !en);
endmodule

bind dev_dma_sequencer dev_dma_sequencer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_reset(bus_reset),
   .cmd_valid(cmd_valid),
   .cmd_code (cmd_code),
   .cnt_load (cnt_load),
   .dma_count(dma_count),
   .dreq     (dreq),
   .dack     (dack),
   .eot      (eot),
   .irq      (irq),
   .irq_ack  (irq_ack),
   .en       (cfg_en)
);

// File: tb/tb_dev_dma_sequencer.sv
module tb_dev_dma_sequencer;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_EP = 16;
   localparam int LVL_W  = 5;
   localparam int CNT_W  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_reset = 1'b0;
   logic cmd_valid = 1'b0;
   logic [7:0] cmd_code = 8'h00;
   logic [15:0] cmd_wdata = 16'h0;
   logic [15:0] cmd_rdata;
   logic cnt_load = 1'b0;
   logic [CNT_W-1:0] cnt_wdata = '0;
   logic [CNT_W-1:0] dma_count;
   logic [NUM_EP*LVL_W-1:0] ep_level = '0;
   logic [NUM_EP-1:0] short_pkt = '0;
   logic dreq, eot, irq;
   logic dack = 1'b0;
   logic irq_ack = 1'b0;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dev_dma_sequencer #(.NUM_EP(NUM_EP), .LVL_W(LVL_W), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
      .cnt_load(cnt_load), .cnt_wdata(cnt_wdata), .dma_count(dma_count),
      .ep_level(ep_level), .short_pkt(short_pkt),
      .dreq(dreq), .dack(dack), .eot(eot), .irq(irq), .irq_ack(irq_ack)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_cmd(input logic [7:0] code, input logic [15:0] w);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = code; cmd_wdata = w;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_code = 8'h00; cmd_wdata = 16'h0;
   endtask

   task automatic rd_cfg(output logic [15:0] v);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = 8'hF1;
      #1 v = cmd_rdata;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_code = 8'h00;
   endtask

   task automatic load_cnt(input logic [15:0] v);
      @(negedge clk);
      cnt_load = 1'b1; cnt_wdata = v;
      @(negedge clk);
      cnt_load = 1'b0;
   endtask

   task automatic ack_bytes(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         dack = 1'b1;
      end
      @(negedge clk);
      dack = 1'b0;
   endtask

   task automatic set_lvl(input int ep, input int v);
      ep_level[ep*LVL_W +: LVL_W] = LVL_W'(v);
   endtask

   task automatic pulse_short(input int ep);
      @(negedge clk);
      short_pkt[ep] = 1'b1;
      @(negedge clk);
      short_pkt = '0;
   endtask

   task automatic clear_irq();
      @(negedge clk);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
   endtask

   task automatic t_reset();
      logic [15:0] v;
      rd_cfg(v);
      chk("R1 cfg", v, 0);
      chk("R1 count", dma_count, 0);
      chk("R1 dreq/eot/irq", {dreq, eot, irq}, 0);
   endtask

   task automatic t_regs();
      logic [15:0] v;
      wr_cmd(8'hF0, 16'hFFF7);
      rd_cfg(v);
      chk("R2 reserved masked", v, 16'hC0F3);
      wr_cmd(8'hF2, 16'h0000);
      rd_cfg(v);
      chk("R2 other code ignored", v, 16'hC0F3);
      @(negedge clk);
      chk("R2 rdata idle zero", cmd_rdata, 0);
      wr_cmd(8'hF0, 16'h0000);
      chk("R8 zero write when stopped no eot", eot, 0);
   endtask

   task automatic t_threshold();
      logic [15:0] v;
      set_lvl(2, 3);
      set_lvl(7, 16);
      wr_cmd(8'hF0, 16'h0029);
      chk("R3 level 3 < burst 4", dreq, 0);
      set_lvl(2, 4);
      #1 chk("R3 level 4 = burst 4", dreq, 1);
      wr_cmd(8'hF0, 16'h002B);
      set_lvl(2, 15);
      #1 chk("R3 level 15 < burst 16, other ep full", dreq, 0);
      set_lvl(2, 16);
      #1 chk("R3 level 16 = burst 16", dreq, 1);
      wr_cmd(8'hF0, 16'h002A);
      set_lvl(2, 7);
      #1 chk("R3 level 7 < burst 8", dreq, 0);
      wr_cmd(8'hF0, 16'h0028);
      set_lvl(2, 0);
      #1 chk("R3 single level 0", dreq, 0);
      set_lvl(2, 1);
      #1 chk("R3 single level 1", dreq, 1);
      wr_cmd(8'hF0, 16'h0020);
      chk("R8 abort eot", eot, 1);
      chk("R11 dreq low when disabled", dreq, 0);
      rd_cfg(v);
      chk("R8 enable cleared", v, 16'h0020);
      clear_irq();
      set_lvl(2, 0); set_lvl(7, 0);
   endtask

   task automatic t_burst_hold();
      set_lvl(2, 4);
      wr_cmd(8'hF0, 16'h0029);
      ack_bytes(1);
      set_lvl(2, 3);
      #1 chk("R4 held mid burst", dreq, 1);
      ack_bytes(2);
      set_lvl(2, 0);
      #1 chk("R4 held before last byte", dreq, 1);
      ack_bytes(1);
      chk("R4 drops after full burst", dreq, 0);
      chk("R6 no eot when counter-stop off", eot, 0);
      wr_cmd(8'hF0, 16'h0020);
      clear_irq();
   endtask

   task automatic t_counter();
      logic [15:0] v;
      load_cnt(3);
      chk("R5 load", dma_count, 3);
      set_lvl(0, 1);
      wr_cmd(8'hF0, 16'h8008);
      ack_bytes(2);
      chk("R5 count down", dma_count, 1);
      chk("R5 no early eot", eot, 0);
      ack_bytes(1);
      chk("R5 eot at zero", eot, 1);
      chk("R5 irq at zero", irq, 1);
      chk("R5 dreq low at zero", dreq, 0);
      chk("R5 count zero", dma_count, 0);
      @(negedge clk);
      chk("R9 eot single pulse", eot, 0);
      chk("R9 irq sticky", irq, 1);
      rd_cfg(v);
      chk("R5 enable cleared", v, 16'h8000);
      clear_irq();
      chk("R9 irq cleared by ack", irq, 0);
      load_cnt(2);
      wr_cmd(8'hF0, 16'h0008);
      ack_bytes(4);
      chk("R6 saturate at zero", dma_count, 0);
      chk("R6 no irq", irq, 0);
      chk("R6 still requesting", dreq, 1);
      wr_cmd(8'hF0, 16'h0000);
      clear_irq();
      set_lvl(0, 0);
   endtask

   task automatic t_short();
      logic [15:0] v;
      wr_cmd(8'hF0, 16'h4058);
      pulse_short(3);
      chk("R7 other ep ignored", irq, 0);
      rd_cfg(v);
      chk("R7 enable kept", v, 16'h4058);
      pulse_short(5);
      chk("R7 short eot", eot, 1);
      chk("R7 short irq", irq, 1);
      clear_irq();
      wr_cmd(8'hF0, 16'h0058);
      pulse_short(5);
      chk("R7 mode off ignored", irq, 0);
      wr_cmd(8'hF0, 16'h0050);
      clear_irq();
   endtask

   task automatic t_bus_reset();
      logic [15:0] v;
      wr_cmd(8'hF0, 16'hC0AA);
      @(negedge clk);
      bus_reset = 1'b1;
      @(negedge clk);
      bus_reset = 1'b0;
      rd_cfg(v);
      chk("R10 only enable cleared", v, 16'hC0A2);
      chk("R10 no irq", irq, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_threshold();
      t_burst_hold();
      t_counter();
      t_short();
      t_bus_reset();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule